// File: doc/BRIEF.md
# IDE Register Window Access Decoder

This block sits between a host I/O port and an ATA task-file register set. Each host cycle carries a size code, a three-bit offset and a window select. The block decides whether the cycle is forwarded, and where it goes. The two windows are a control window and a data window.

In the control window, only one single-byte location is passed on. Reading it returns the alternate status, and writing it updates the device-control byte. In the data window, a single-byte access reaches the task-file register named by its offset. An aligned halfword or word access reaches the 16-bit or 32-bit data port.

Any other access is not forwarded. A read of that kind returns all ones, sized to the access, and a write of that kind is dropped. Read data is right-aligned and little-endian, and it is valid in the same cycle as the read strobe. Every data-port read is followed by a registered one-cycle pulse, which lets the downstream buffer pointer advance.

Top module: `ide_window_decoder`

## Requirements
- R1: In the control window (`win_i`=1), a byte read (size code 0) at offset 2 asserts `ctl_rd_o`. In the same cycle, `rdata_o` equals `alt_status_i`, zero-extended to 32 bits.
- R2: In the control window, a byte write at offset 2 asserts `ctl_wr_o`, and `ctl_wdata_o` equals `wdata_i[7:0]`.
- R3: Any other control-window read asserts no strobe. It returns 0xFF for size code 0, 0xFFFF for size code 1 and 0xFFFFFFFF for size code 2.
- R4: Any other control-window write asserts no strobe, and the device-control byte seen downstream keeps its value.
- R5: In the data window (`win_i`=0), a byte access at offset n asserts `reg_rd_o` or `reg_wr_o` with `reg_idx_o`=n. A read returns the register byte in `rdata_o[7:0]` with the upper bits zero. A write drives `wdata_i[7:0]` on `reg_wdata_o`.
- R6: In the data window, a halfword access (size code 1) at offset 0 asserts `dp_rd_o` or `dp_wr_o` with `dp_wide_o`=0. A read returns `dp_rdata_i[15:0]`, zero-extended. A write drives `wdata_i[15:0]` on `dp_wdata_o[15:0]` with the upper half zero.
- R7: In the data window, a word access (size code 2) at offset 0 asserts the data-port strobe with `dp_wide_o`=1. It carries all 32 bits in both directions.
- R8: A data-window halfword or word access at a non-zero offset asserts no strobe. A read returns all ones of the access width, and a write is dropped.
- R9: Size code 3 is reserved. In either window it asserts no strobe and reads as 0xFFFFFFFF.
- R10: `dp_adv_o` is high for exactly the one cycle after each cycle in which `dp_rd_o` is high, and low otherwise. It is low after reset.
- R11: While `req_i` is low, no strobe is asserted and `rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Host access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| win_i | input | 1 | 1 = control window, 0 = data window |
| off_i | input | 3 | Byte offset within the window |
| size_i | input | 2 | Size code: 0 byte, 1 halfword, 2 word, 3 reserved |
| wdata_i | input | 32 | Right-aligned host write data |
| rdata_o | output | 32 | Right-aligned host read data |
| reg_rd_o | output | 1 | Task-file register read strobe |
| reg_wr_o | output | 1 | Task-file register write strobe |
| reg_idx_o | output | 3 | Task-file register index |
| reg_wdata_o | output | 8 | Task-file register write byte |
| reg_rdata_i | input | 8 | Selected task-file register value |
| ctl_rd_o | output | 1 | Alternate-status read strobe |
| ctl_wr_o | output | 1 | Device-control write strobe |
| ctl_wdata_o | output | 8 | Device-control write byte |
| alt_status_i | input | 8 | Alternate status value |
| dp_rd_o | output | 1 | Data-port read strobe |
| dp_wr_o | output | 1 | Data-port write strobe |
| dp_wide_o | output | 1 | Data-port access is 32-bit |
| dp_wdata_o | output | 32 | Data-port write data |
| dp_rdata_i | input | 32 | Data-port read data |
| dp_adv_o | output | 1 | Registered pulse after each data-port read |

## Verification
The bench builds the decoder with its default parameters: a 32-bit host bus, a 3-bit offset and the control byte at offset 2. With these values every pairing of window, offset and size code can occur. Random stimulus covers that whole space, and a bench model of the eight task-file registers checks that byte writes land at the offset they name. The reserved size code, misaligned wide accesses and back-to-back data-port reads, which exercise the advance pulse, are also reached.

// File: rtl/ide_win_pkg.sv
package ide_win_pkg;
  localparam int unsigned BUS_W = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSV  = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    K_IDLE,
    K_CTRL,
    K_TFREG,
    K_DP16,
    K_DP32,
    K_ONES
  } acc_kind_e;

  function automatic logic [BUS_W-1:0] ones_for(acc_size_e s);
    case (s)
      SZ_BYTE: ones_for = BUS_W'(8'hFF);
      SZ_HALF: ones_for = BUS_W'(16'hFFFF);
      default: ones_for = '1;
    endcase
  endfunction
endpackage

// File: rtl/ide_win_classify.sv
module ide_win_classify
  import ide_win_pkg::*;
#(
  parameter int unsigned OFF_W    = 3,
  parameter int unsigned CTRL_OFF = 2
) (
  input  logic             req_i,
  input  logic             win_i,
  input  logic [OFF_W-1:0] off_i,
  input  acc_size_e        size_i,
  output acc_kind_e        kind_o
);
  logic aligned;
  assign aligned = (off_i == '0);

  always_comb begin
    kind_o = K_IDLE;
    if (req_i) begin
      if (win_i) begin
        kind_o = (size_i == SZ_BYTE && off_i == OFF_W'(CTRL_OFF)) ? K_CTRL : K_ONES;
      end else begin
        case (size_i)
          SZ_BYTE: kind_o = K_TFREG;
          SZ_HALF: kind_o = aligned ? K_DP16 : K_ONES;
          SZ_WORD: kind_o = aligned ? K_DP32 : K_ONES;
          default: kind_o = K_ONES;
        endcase
      end
    end
  end
endmodule

// File: rtl/ide_win_rdmux.sv
module ide_win_rdmux
  import ide_win_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  acc_kind_e         kind_i,
  input  acc_size_e         size_i,
  input  logic [REG_W-1:0]  alt_status_i,
  input  logic [REG_W-1:0]  reg_rdata_i,
  input  logic [BUS_W-1:0]  dp_rdata_i,
  output logic [BUS_W-1:0]  rdata_o
);
  localparam int unsigned HALF_W = BUS_W / 2;

  always_comb begin
    case (kind_i)
      K_CTRL:  rdata_o = BUS_W'(alt_status_i);
      K_TFREG: rdata_o = BUS_W'(reg_rdata_i);
      K_DP16:  rdata_o = BUS_W'(dp_rdata_i[HALF_W-1:0]);
      K_DP32:  rdata_o = dp_rdata_i;
      K_ONES:  rdata_o = ones_for(size_i);
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ide_window_decoder.sv
module ide_window_decoder
  import ide_win_pkg::*;
#(
  parameter int unsigned OFF_W    = 3,
  parameter int unsigned REG_W    = 8,
  parameter int unsigned CTRL_OFF = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             win_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [1:0]       size_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  output logic             reg_rd_o,
  output logic             reg_wr_o,
  output logic [OFF_W-1:0] reg_idx_o,
  output logic [REG_W-1:0] reg_wdata_o,
  input  logic [REG_W-1:0] reg_rdata_i,
  output logic             ctl_rd_o,
  output logic             ctl_wr_o,
  output logic [REG_W-1:0] ctl_wdata_o,
  input  logic [REG_W-1:0] alt_status_i,
  output logic             dp_rd_o,
  output logic             dp_wr_o,
  output logic             dp_wide_o,
  output logic [31:0]      dp_wdata_o,
  input  logic [31:0]      dp_rdata_i,
  output logic             dp_adv_o
);
  localparam int unsigned HALF_W = BUS_W / 2;

  acc_size_e size;
  acc_kind_e kind;
  logic      is_dp;
  logic      dp_adv_q;

  assign size = acc_size_e'(size_i);

  ide_win_classify #(.OFF_W(OFF_W), .CTRL_OFF(CTRL_OFF)) i_classify (
    .req_i  (req_i),
    .win_i  (win_i),
    .off_i  (off_i),
    .size_i (size),
    .kind_o (kind)
  );

  ide_win_rdmux #(.REG_W(REG_W)) i_rdmux (
    .kind_i       (kind),
    .size_i       (size),
    .alt_status_i (alt_status_i),
    .reg_rdata_i  (reg_rdata_i),
    .dp_rdata_i   (dp_rdata_i),
    .rdata_o      (rdata_o)
  );

  assign is_dp       = (kind == K_DP16) || (kind == K_DP32);
  assign reg_rd_o    = (kind == K_TFREG) && !we_i;
  assign reg_wr_o    = (kind == K_TFREG) && we_i;
  assign reg_idx_o   = off_i;
  assign reg_wdata_o = wdata_i[REG_W-1:0];
  assign ctl_rd_o    = (kind == K_CTRL) && !we_i;
  assign ctl_wr_o    = (kind == K_CTRL) && we_i;
  assign ctl_wdata_o = wdata_i[REG_W-1:0];
  assign dp_rd_o     = is_dp && !we_i;
  assign dp_wr_o     = is_dp && we_i;
  assign dp_wide_o   = (kind == K_DP32);
  assign dp_wdata_o  = dp_wide_o ? wdata_i : BUS_W'(wdata_i[HALF_W-1:0]);

  // buffer pointer advance follows each data-port read by one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dp_adv_q <= 1'b0;
    else         dp_adv_q <= dp_rd_o;
  end
  assign dp_adv_o = dp_adv_q;

  logic [5:0] strobes;
  assign strobes = {reg_rd_o, reg_wr_o, ctl_rd_o, ctl_wr_o, dp_rd_o, dp_wr_o};

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(strobes)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> (strobes == '0 && rdata_o == '0)); // R11
  AST_CTRL_SITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_rd_o || ctl_wr_o) |-> (win_i && size_i == 2'd0 && off_i == OFF_W'(CTRL_OFF))); // R1
  AST_CTRL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && win_i && we_i && !(size_i == 2'd0 && off_i == OFF_W'(CTRL_OFF)))
      |-> strobes == '0); // R4
  AST_CTRL_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && win_i && !we_i && size_i == 2'd0 && off_i != OFF_W'(CTRL_OFF))
      |-> rdata_o == 32'hFF); // R3
  AST_WIDE_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dp_rd_o || dp_wr_o) |-> (!win_i && off_i == '0)); // R8
  AST_RSV_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && size_i == 2'd3) |-> (strobes == '0 && (we_i || rdata_o == '1))); // R9
  AST_ADV_AFTER_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dp_rd_o |=> dp_adv_o); // R10
  AST_ADV_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dp_adv_o) |-> $past(dp_rd_o)); // R10
endmodule

// File: tb/test_ide_window_decoder.sv
module test_ide_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, win = 1'b0;
  logic [2:0]  off = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0, rdata;
  logic        reg_rd, reg_wr, ctl_rd, ctl_wr, dp_rd, dp_wr, dp_wide, dp_adv;
  logic [2:0]  reg_idx;
  logic [7:0]  reg_wdata, reg_rdata, ctl_wdata;
  logic [7:0]  alt_status = 8'h50;
  logic [31:0] dp_wdata, dp_rdata = '0;

  logic [7:0]  regs [8];
  logic [7:0]  devctl;
  int          checks = 0, failures = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  ide_window_decoder i_ide_window_decoder (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .win_i(win),
    .off_i(off), .size_i(size), .wdata_i(wdata), .rdata_o(rdata),
    .reg_rd_o(reg_rd), .reg_wr_o(reg_wr), .reg_idx_o(reg_idx),
    .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata),
    .ctl_rd_o(ctl_rd), .ctl_wr_o(ctl_wr), .ctl_wdata_o(ctl_wdata),
    .alt_status_i(alt_status), .dp_rd_o(dp_rd), .dp_wr_o(dp_wr),
    .dp_wide_o(dp_wide), .dp_wdata_o(dp_wdata), .dp_rdata_i(dp_rdata),
    .dp_adv_o(dp_adv)
  );

  assign reg_rdata = regs[reg_idx];

  always @(posedge clk) begin
    if (reg_wr) regs[reg_idx] <= reg_wdata;
    if (ctl_wr) devctl <= ctl_wdata;
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ones(logic [1:0] s);
    return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  // order {reg_rd, reg_wr, ctl_rd, ctl_wr, dp_rd, dp_wr}
  function automatic logic [5:0] exp_strobes(logic w, logic e, logic [2:0] o, logic [1:0] s);
    if (s == 2'd3) return '0;
    if (w) return (s == 2'd0 && o == 3'd2) ? (e ? 6'b000100 : 6'b001000) : '0;
    if (s == 2'd0) return e ? 6'b010000 : 6'b100000;
    if (o != 3'd0) return '0;
    return e ? 6'b000001 : 6'b000010;
  endfunction

  function automatic logic [31:0] exp_rdata(logic w, logic [2:0] o, logic [1:0] s);
    if (s == 2'd3) return 32'hFFFF_FFFF;
    if (w) return (s == 2'd0 && o == 3'd2) ? {24'h0, alt_status} : ones(s);
    if (s == 2'd0) return {24'h0, regs[o]};
    if (o != 3'd0) return ones(s);
    return (s == 2'd1) ? {16'h0, dp_rdata[15:0]} : dp_rdata;
  endfunction

  function automatic string tag_of(logic w, logic e, logic [2:0] o, logic [1:0] s);
    if (s == 2'd3) return "R9";
    if (w) begin
      if (s == 2'd0 && o == 3'd2) return e ? "R2" : "R1";
      return e ? "R4" : "R3";
    end
    if (s == 2'd0) return "R5";
    if (o != 3'd0) return "R8";
    return (s == 2'd1) ? "R6" : "R7";
  endfunction

  task automatic access(logic w, logic e, logic [2:0] o, logic [1:0] s, logic [31:0] d);
    logic [5:0]  es;
    logic [31:0] er;
    logic [7:0]  dc_before;
    string       t;
    @(negedge clk);
    req = 1'b1; win = w; we = e; off = o; size = s; wdata = d;
    dp_rdata = $urandom; alt_status = 8'($urandom);
    #1;
    es = exp_strobes(w, e, o, s);
    er = exp_rdata(w, o, s);
    t = tag_of(w, e, o, s);
    dc_before = devctl;
    chk({reg_rd, reg_wr, ctl_rd, ctl_wr, dp_rd, dp_wr} == es, t,
        32'({reg_rd, reg_wr, ctl_rd, ctl_wr, dp_rd, dp_wr}), 32'(es));
    if (!e) chk(rdata == er, t, rdata, er);
    if (e && es[4]) chk(reg_idx == o && reg_wdata == d[7:0], "R5", {21'h0, reg_idx, reg_wdata}, {21'h0, o, d[7:0]});
    if (!e && es[5]) chk(reg_idx == o, "R5", 32'(reg_idx), 32'(o));
    if (e && es[2]) chk(ctl_wdata == d[7:0], "R2", 32'(ctl_wdata), 32'(d[7:0]));
    if (es[1] || es[0]) begin
      chk(dp_wide == (s == 2'd2), t, 32'(dp_wide), 32'(s == 2'd2));
      if (e) chk(dp_wdata == ((s == 2'd2) ? d : {16'h0, d[15:0]}), t, dp_wdata,
                 (s == 2'd2) ? d : {16'h0, d[15:0]});
    end
    @(posedge clk); #1;
    chk(dp_adv == es[1], "R10", 32'(dp_adv), 32'(es[1]));
    if (w && e && !es[2]) chk(devctl == dc_before, "R4", 32'(devctl), 32'(dc_before));
  endtask

  task automatic idle_check();
    @(negedge clk);
    req = 1'b0; we = 1'($urandom); win = 1'($urandom); off = 3'($urandom); size = 2'($urandom);
    #1;
    chk({reg_rd, reg_wr, ctl_rd, ctl_wr, dp_rd, dp_wr} == '0 && rdata == '0, "R11", rdata, 32'h0);
    @(posedge clk); #1;
    chk(dp_adv == 1'b0, "R10", 32'(dp_adv), 32'h0);
  endtask

  initial begin
    void'($urandom(32'h1DE0_5EED));
    for (int i = 0; i < 8; i++) regs[i] = 8'(i * 17);
    devctl = 8'h00;
    #9;
    chk(dp_adv == 1'b0, "R10", 32'(dp_adv), 32'h0);
    rst_n = 1'b1;
    idle_check();
    // directed corners
    access(1, 0, 3'd2, 2'd0, 0);              // R1
    access(1, 1, 3'd2, 2'd0, 32'hA5A5_A50C);   // R2
    access(1, 0, 3'd2, 2'd1, 0);              // R3 halfword
    access(1, 0, 3'd0, 2'd2, 0);              // R3 word
    access(1, 0, 3'd6, 2'd0, 0);              // R3 byte
    access(1, 1, 3'd3, 2'd0, 32'hFF);         // R4
    access(1, 1, 3'd2, 2'd2, 32'h33);         // R4 wide at control byte
    for (int i = 0; i < 8; i++) access(0, 1, 3'(i), 2'd0, 32'(8'hC0 + i));
    for (int i = 0; i < 8; i++) access(0, 0, 3'(i), 2'd0, 0);  // R5 readback
    access(0, 0, 3'd0, 2'd1, 0);              // R6
    access(0, 1, 3'd0, 2'd1, 32'hDEAD_BEEF);  // R6
    access(0, 0, 3'd0, 2'd2, 0);              // R7 back-to-back reads
    access(0, 0, 3'd0, 2'd2, 0);
    access(0, 1, 3'd0, 2'd2, 32'h1234_5678);  // R7
    access(0, 0, 3'd2, 2'd1, 0);              // R8
    access(0, 0, 3'd4, 2'd2, 0);              // R8
    access(0, 1, 3'd4, 2'd2, 32'h77);         // R8
    access(0, 0, 3'd0, 2'd3, 0);              // R9
    access(1, 0, 3'd2, 2'd3, 0);              // R9
    idle_check();
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 9) == 0) idle_check();
      else access(1'($urandom), 1'($urandom), 3'($urandom), 2'($urandom), $urandom);
    end
    @(negedge clk); req = 1'b0;
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule